// File: doc/BRIEF.md
# Decision-Directed Symbol Timing Loop

This block recovers symbol timing from a real baseband stream that arrives at a nominal eight samples per symbol. It emits one decision sample per symbol together with a one-cycle ready pulse. It also drives a quantised fractional-phase index, which an external fractional-delay interpolator uses to pick its coefficient set. Each incoming sample comes with a strobe. The block keeps a symbol-clock counter in fixed point. Every strobe moves the counter down by one sample. When the counter falls below one sample, a symbol instant is declared.

At each symbol instant the sign of the current sample serves as the hard decision. A cross-product timing error is formed from that decision, the current sample, and the sample and decision of the previous symbol. Two programmable gains then steer the loop. The first adds a scaled error to the symbol-period estimate, which is held inside a window around its midpoint. The second adds a scaled error to the fractional phase. Any whole samples that spill out of the phase are handed to the counter. The counter is then reloaded from the new period, so the symbol clock stretches or shrinks one symbol at a time.

All period, phase and gain quantities are signed fixed point with 13 fractional bits, so 1.0 is 8192. Samples use the same scaling.

Top module: `mm_timing_loop`

## Requirements
- R1: With both gains at zero, a symbol instant falls on the first strobe after reset and then on every 8th strobe.
- R2: The decision for a sample is +1 when the sample is zero or positive and -1 when it is negative (the sign bit of the 16-bit two's-complement sample). The error is e = d_prev*y - d*y_prev, where y and d are the current symbol sample and its decision, and y_prev and d_prev belong to the previous symbol instant.
- R3: At a symbol instant the period becomes P + floor(gain_omega*e / 8192), limited to the range [PERIOD_MID - PERIOD_REL, PERIOD_MID + PERIOD_REL]. With the defaults and gain_mu at zero, two consecutive symbol instants are therefore 7 to 9 strobes apart.
- R4: At a symbol instant the phase sum is S = mu + floor(gain_mu*e / 8192). The phase keeps the fraction S mod 8192, in the range [0, 8191]. The whole part S minus that fraction is passed to the counter.
- R5: On a strobe where the counter is at least 8192, the counter drops by 8192. On a strobe where the counter is below 8192, a symbol instant occurs and the counter becomes counter + new period + whole part - 8192.
- R6: sym_rdy is high for exactly the one cycle after the clock edge that accepted a symbol-instant strobe. In that cycle sym_out equals that strobe's sample.
- R7: phase_idx equals floor((mu + 32) / 64), so it always lies in 0..128. It changes only together with sym_rdy.
- R8: A cycle with in_vld low leaves sym_rdy low and both sym_out and phase_idx unchanged.
- R9: Synchronous active-high reset clears sym_rdy, sym_out, phase_idx, the phase, the counter and the previous-symbol history, and loads the period with PERIOD_MID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Strobe marking a new input sample |
| in_smp | input | 16 | Signed input sample, 13 fractional bits |
| gain_omega | input | 16 | Signed period gain, 13 fractional bits |
| gain_mu | input | 16 | Signed phase gain, 13 fractional bits |
| sym_rdy | output | 1 | One-cycle pulse for a new symbol sample |
| sym_out | output | 16 | Sample taken at the last symbol instant |
| phase_idx | output | 8 | Fractional phase quantised to 0..128 |

## Verification
Every internal register of the loop shows up at the ports within one symbol. A wrong period or a wrong counter reload moves the next sym_rdy pulse by one or more strobes. A wrong fraction or a wrong carry shows up in phase_idx on the same pulse. A wrong decision or a stale history shifts the pulse or the index at the following symbol instant.

The bench runs a reference model of the requirements, one strobe at a time, over several gain pairs and sample patterns. It compares the timing of every pulse, the sample and the index. Directed cases cover the nominal period of eight, the clamp-bounded spacing, idle cycles, and zero samples that must count as positive.

// File: rtl/mmtr_pkg.sv
package mmtr_pkg;

    // fixed-point format shared by period, phase, counter and gains
    localparam int FRAC  = 13;
    localparam int ACC_W = 24;

    typedef logic signed [ACC_W-1:0] acc_t;

    localparam acc_t ONE      = acc_t'(1 << FRAC);
    localparam acc_t FRAC_MSK = ONE - acc_t'(1);

    // result of one loop-filter step
    typedef struct packed {
        acc_t period;
        acc_t frac;
        acc_t whole;
    } loop_upd_t;

    // multiply by the hard decision of a sample (negative -> -1, else +1)
    function automatic acc_t by_decision(input logic neg, input acc_t v);
        return neg ? -v : v;
    endfunction

    // clamp into [lo, hi]
    function automatic acc_t clamp(input acc_t v, input acc_t lo, input acc_t hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/mmtr_ted.sv
module mmtr_ted
    import mmtr_pkg::*;
#(
    parameter int SMP_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [SMP_W-1:0] in_smp,
    input  logic                    take,
    output acc_t                    err
);
    logic signed [SMP_W-1:0] prev_q;
    acc_t cur_x, prev_x;

    assign cur_x  = acc_t'(in_smp);
    assign prev_x = acc_t'(prev_q);

    // decision folded into the detector: sign bit picks +/-1
    assign err = by_decision(prev_q[SMP_W-1], cur_x)
               - by_decision(in_smp[SMP_W-1], prev_x);

    always_ff @(posedge clk) begin
        if (rst)       prev_q <= '0;
        else if (take) prev_q <= in_smp;
    end
endmodule

// File: rtl/mmtr_loop.sv
module mmtr_loop
    import mmtr_pkg::*;
#(
    parameter int GAIN_W     = 16,
    parameter int PERIOD_MID = 65536,
    parameter int PERIOD_REL = 4096
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     take,
    input  acc_t                     err,
    input  logic signed [GAIN_W-1:0] gain_omega,
    input  logic signed [GAIN_W-1:0] gain_mu,
    output loop_upd_t                upd,
    output acc_t                     mu_q
);
    localparam int   PW    = GAIN_W + ACC_W;
    localparam acc_t P_MID = acc_t'(PERIOD_MID);
    localparam acc_t P_LO  = acc_t'(PERIOD_MID - PERIOD_REL);
    localparam acc_t P_HI  = acc_t'(PERIOD_MID + PERIOD_REL);

    acc_t period_q;
    logic signed [PW-1:0] prod_w, prod_m;
    acc_t step_w, step_m, mu_sum;

    assign prod_w = PW'(gain_omega) * PW'(err);
    assign prod_m = PW'(gain_mu) * PW'(err);
    assign step_w = acc_t'(prod_w >>> FRAC);
    assign step_m = acc_t'(prod_m >>> FRAC);
    assign mu_sum = mu_q + step_m;

    always_comb begin
        upd.period = clamp(period_q + step_w, P_LO, P_HI);
        upd.frac   = mu_sum & FRAC_MSK;
        upd.whole  = mu_sum - upd.frac;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= P_MID;
            mu_q     <= '0;
        end else if (take) begin
            period_q <= upd.period;
            mu_q     <= upd.frac;
        end
    end
endmodule

// File: rtl/mmtr_clock.sv
module mmtr_clock
    import mmtr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_vld,
    input  loop_upd_t upd,
    output logic      fire
);
    acc_t cnt_q;

    assign fire = in_vld && (cnt_q < ONE);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (fire)
            cnt_q <= cnt_q + upd.period + upd.whole - ONE;
        else if (in_vld)
            cnt_q <= cnt_q - ONE;
    end
endmodule

// File: rtl/mm_timing_loop.sv
module mm_timing_loop
    import mmtr_pkg::*;
#(
    parameter int SMP_W      = 16,
    parameter int GAIN_W     = 16,
    parameter int IDX_W      = 8,
    parameter int PERIOD_MID = 65536,
    parameter int PERIOD_REL = 4096
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_vld,
    input  logic signed [SMP_W-1:0]  in_smp,
    input  logic signed [GAIN_W-1:0] gain_omega,
    input  logic signed [GAIN_W-1:0] gain_mu,
    output logic                     sym_rdy,
    output logic signed [SMP_W-1:0]  sym_out,
    output logic [IDX_W-1:0]         phase_idx
);
    localparam int   IDX_SH = FRAC - 7;
    localparam acc_t IDX_RND = acc_t'(1 << (IDX_SH - 1));

    acc_t      err;
    acc_t      mu_q;
    loop_upd_t upd;
    logic      fire;

    mmtr_ted #(.SMP_W(SMP_W)) u_ted (
        .clk(clk), .rst(rst), .in_smp(in_smp), .take(fire), .err(err)
    );

    mmtr_loop #(
        .GAIN_W(GAIN_W), .PERIOD_MID(PERIOD_MID), .PERIOD_REL(PERIOD_REL)
    ) u_loop (
        .clk(clk), .rst(rst), .take(fire), .err(err),
        .gain_omega(gain_omega), .gain_mu(gain_mu),
        .upd(upd), .mu_q(mu_q)
    );

    mmtr_clock u_clk (
        .clk(clk), .rst(rst), .in_vld(in_vld), .upd(upd), .fire(fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_rdy <= 1'b0;
            sym_out <= '0;
        end else begin
            sym_rdy <= fire;
            if (fire) sym_out <= in_smp;
        end
    end

    // 129-step quantisation of the registered fractional phase
    assign phase_idx = IDX_W'((mu_q + IDX_RND) >>> IDX_SH);
endmodule

// File: rtl/mm_timing_loop_chk.sv
module mm_timing_loop_chk #(
    parameter int SMP_W = 16,
    parameter int IDX_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_vld,
    input logic signed [SMP_W-1:0] in_smp,
    input logic                    sym_rdy,
    input logic signed [SMP_W-1:0] sym_out,
    input logic [IDX_W-1:0]        phase_idx
);
    // R6
    rdy_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        sym_rdy |-> $past(in_vld));

    // R6
    sym_sample_chk: assert property (@(posedge clk) disable iff (rst)
        sym_rdy |-> (sym_out == $past(in_smp)));

    // R7
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        phase_idx <= IDX_W'(128));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(in_vld) |-> (!sym_rdy && $stable(phase_idx) && $stable(sym_out)));

    // R9
    reset_out_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sym_rdy && phase_idx == '0 && sym_out == '0));
endmodule

bind mm_timing_loop mm_timing_loop_chk #(.SMP_W(SMP_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_smp(in_smp),
    .sym_rdy(sym_rdy), .sym_out(sym_out), .phase_idx(phase_idx)
);

// File: tb/tb_mm_timing_loop.sv
module tb_mm_timing_loop;
    localparam int CLK_PERIOD = 10;
    localparam longint ONE_V = 8192;
    localparam longint P_MID = 65536;
    localparam longint P_REL = 4096;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_vld = 1'b0;
    logic signed [15:0] in_smp = '0;
    logic signed [15:0] gain_omega = '0;
    logic signed [15:0] gain_mu = '0;
    logic sym_rdy;
    logic signed [15:0] sym_out;
    logic [7:0] phase_idx;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    longint m_cnt, m_per, m_mu, m_prev, m_sym;

    mm_timing_loop dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_smp(in_smp),
        .gain_omega(gain_omega), .gain_mu(gain_mu),
        .sym_rdy(sym_rdy), .sym_out(sym_out), .phase_idx(phase_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    task automatic do_reset(input int gw, input int gm);
        @(negedge clk);
        rst = 1'b1; in_vld = 1'b0; in_smp = '0;
        gain_omega = 16'(gw); gain_mu = 16'(gm);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_cnt = 0; m_per = P_MID; m_mu = 0; m_prev = 0; m_sym = 0;
    endtask

    // model one strobe from the requirement arithmetic
    function automatic bit model_step(input longint y);
        longint e, p, s, fr;
        if (m_cnt < ONE_V) begin
            e = ((m_prev < 0) ? -y : y) - ((y < 0) ? -m_prev : m_prev);
            p = m_per + ((longint'(gain_omega) * e) >>> 13);
            if (p < P_MID - P_REL) p = P_MID - P_REL;
            if (p > P_MID + P_REL) p = P_MID + P_REL;
            s  = m_mu + ((longint'(gain_mu) * e) >>> 13);
            fr = s & (ONE_V - 1);
            m_cnt = m_cnt + p + (s - fr) - ONE_V;
            m_per = p; m_mu = fr; m_prev = y; m_sym = y;
            return 1;
        end
        m_cnt = m_cnt - ONE_V;
        return 0;
    endfunction

    // one idle cycle, then a strobe; compare against the model
    task automatic push(input logic signed [15:0] s, output bit got);
        bit expf;
        logic [7:0] ph0;
        logic signed [15:0] so0;
        ph0 = phase_idx; so0 = sym_out;
        @(negedge clk);
        check(sym_rdy == 1'b0, "R8 idle rdy", sym_rdy, 0);
        check(phase_idx == ph0 && sym_out == so0, "R8 idle hold", phase_idx, ph0);
        in_vld = 1'b1; in_smp = s;
        @(negedge clk);
        in_vld = 1'b0;
        expf = model_step(longint'(s));
        got = sym_rdy;
        check(sym_rdy == expf, "R5 R6 ready timing", sym_rdy, expf);
        if (expf) check(sym_out == 16'(m_sym), "R6 symbol sample", sym_out, m_sym);
        check(phase_idx == 8'((m_mu + 32) >>> 6), "R4 R7 phase index", phase_idx, (m_mu + 32) >>> 6);
    endtask

    function automatic logic signed [15:0] gen(input int pat, input int i);
        int r;
        r = int'($urandom_range(0, 65535)) - 32768;
        case (pat)
            0: return 16'(r);
            1: return 16'(((i % 8) < 4 ? 6000 : -6000) + (r >>> 8));
            2: case (i % 4)
                   0: return 16'sd0;
                   1: return 16'sd8192;
                   2: return -16'sd8192;
                   default: return 16'(r >>> 3);
               endcase
            default: return 16'(((i % 16) < 8 ? 1 : -1) * (3000 + (i % 8) * 900));
        endcase
    endfunction

    task automatic run(input int gw, input int gm, input int pat, input int n);
        bit got;
        int last;
        last = -1;
        do_reset(gw, gm);
        for (int i = 0; i < n; i++) begin
            push(gen(pat, i), got);
            if (got) begin
                if (gw == 0 && gm == 0) begin
                    // R1 nominal spacing of eight strobes
                    check(i % 8 == 0, "R1 nominal period", i, (i / 8) * 8);
                end else if (gm == 0 && last >= 0) begin
                    // R3 clamp bounds spacing to 7..9 strobes
                    check(i - last >= 7 && i - last <= 9, "R3 clamped spacing", i - last, 8);
                end
                last = i;
            end
        end
    endtask

    initial begin
        bit got;
        int fires[$];

        // R9 reset state
        do_reset(0, 0);
        @(negedge clk);
        check(sym_rdy == 1'b0, "R9 reset rdy", sym_rdy, 0);
        check(sym_out == 16'sd0, "R9 reset sym_out", sym_out, 0);
        check(phase_idx == 8'd0, "R9 reset phase", phase_idx, 0);

        // R2 zero sample counts as +1: symbols at strobes 0, 7, 16
        do_reset(0, 8192);
        for (int i = 0; i < 20; i++) begin
            push((i == 0) ? -16'sd8192 : ((i == 7) ? 16'sd0 : 16'sd1000), got);
            if (got) fires.push_back(i);
        end
        check(fires.size() >= 3, "R2 symbol count", fires.size(), 3);
        if (fires.size() >= 3) begin
            check(fires[0] == 0, "R2 first symbol", fires[0], 0);
            check(fires[1] == 7, "R4 carry shortens", fires[1], 7);
            check(fires[2] == 16, "R2 zero decision positive", fires[2], 16);
        end

        // model sweeps over gains and patterns
        run(0, 0, 0, 200);
        run(0, 0, 2, 120);
        run(300, 0, 1, 300);
        run(32767, 0, 0, 300);
        run(-20000, 0, 3, 300);
        run(200, 800, 1, 300);
        run(150, 4096, 0, 300);
        run(-400, -1500, 2, 300);
        run(1000, 2000, 3, 300);

        summary();
    end
endmodule